// File: doc/BRIEF.md
# Thermal Threshold and Out-of-Spec Monitor

This block watches a stream of digital die-temperature samples and turns them into thermal event logs, live status and a single interrupt line. Software programs two independent temperature thresholds. Every time a new sample moves the temperature across one of them, upward or downward, the block records a log bit for that threshold and that direction. Each log bit has its own interrupt enable.

The block also gives early warning of a thermal runaway. Throttling is already engaged, in either throttle mode, and is reported on one input. If the temperature still stays at or above a programmed trip level for a programmed number of consecutive samples, the block sets a live out-of-spec status bit and a sticky copy of it. The sticky copy can raise the interrupt. The warning is meant to fire well before the hardware shutdown trip, so the system still has time to shut down in an orderly way. The sensor, the shutdown trip and the interrupt controller sit outside this block.

Top module: `thermal_oos_monitor`

## Requirements
- R1: After reset, every bit of `status` is 0 and `irq` is 0. Both thresholds and the trip level reset to all ones, the persistence length resets to 1 and all interrupt enables reset to 0.
- R2: A sample at or above threshold k, when the previous sample was below it, sets the upward log of threshold k. The upward log of threshold k is status bit 2k. It is visible in the cycle after the sample.
- R3: A sample below threshold k, when the previous sample was at or above it, sets the downward log of threshold k. The downward log of threshold k is status bit 2k+1.
- R4: The first sample after reset never sets a log. A sample that stays on the same side of a threshold as the previous sample leaves that threshold's logs unchanged.
- R5: Status bit 2N+2+k is 1 exactly when the most recent sample was at or above threshold k, where N is the number of thresholds (N=2, so bits 6 and 7).
- R6: A sample qualifies when `throttle_on` is 1 and the temperature is at or above the trip level. After P consecutive qualifying samples, the out-of-spec live bit (status bit 2N+1) and the out-of-spec sticky bit (status bit 2N) are set, where P is the programmed persistence length. A length of 0 acts as 1.
- R7: A non-qualifying sample restarts the consecutive count and clears the live bit. The sticky bit stays set.
- R8: While `throttle_on` is 0, no temperature makes the live or sticky out-of-spec bit set.
- R9: A write to the clear address (N+3) clears every log or sticky bit whose mask bit is 1. The mask uses the status bit positions 0..2N. A bit being set in the same cycle wins over the clear, and the out-of-spec sticky bit cannot be cleared while the live bit is 1.
- R10: `irq` is 1 exactly when some bit among status bits 0..2N is set and has its enable bit set. The enable register is at address N+2 and uses the same bit positions. The line follows the registers with no extra delay.
- R11: In a cycle with no sample and no clear write, `status` holds its value. Writes to the thresholds, the trip level, the persistence length or the enables leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | A new temperature sample is present this cycle |
| temp_code | input | TEMP_W | Temperature sample, unsigned, higher is hotter |
| throttle_on | input | 1 | Throttling of either kind is currently active |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Write address: k = threshold k, N = trip level, N+1 = persistence length, N+2 = enables, N+3 = clear mask |
| wr_data | input | DATA_W | Write data |
| status | output | 3*N+2 | Logs, out-of-spec sticky and live bits, live above-threshold bits |
| irq | output | 1 | Thermal interrupt |

## Verification
The hardest state to reach from the ports is a clear write that lands in the same cycle as the event it would erase. A related case is a clear of the out-of-spec sticky bit while the condition is still live. The bench reaches the first case by raising the clear write and a qualifying sample in the same cycle, with the persistence length at 0 so that the single sample trips. It reaches the second by issuing a clear while throttling and heat continue. It then checks that the bit survives and can be cleared only after a cooler sample has dropped the live bit.

// File: rtl/thermal_mon_pkg.sv
// Package: shared types for the thermal threshold / out-of-spec monitor.
// Assumes nothing beyond IEEE 1800-2017; used by every module of the block.
package thermal_mon_pkg;

    // Width of the configuration write address.
    localparam int unsigned CFG_ADDR_W = 3;

    // Kind of threshold crossing seen between two consecutive samples.
    typedef enum logic [1:0] {
        XING_NONE = 2'd0,
        XING_UP   = 2'd1,
        XING_DOWN = 2'd2
    } xing_e;

endpackage

// File: rtl/tm_cfg_regs.sv
// Module: tm_cfg_regs
// Holds the programmable configuration: one level per threshold, the
// out-of-spec trip level, the persistence length and the interrupt enables.
// Also decodes the clear address into a one-cycle clear mask.
// Assumes DATA_W is at least TEMP_W, CNT_W and 2*NUM_THR+1.
module tm_cfg_regs #(
    parameter int unsigned NUM_THR = 2,
    parameter int unsigned TEMP_W  = 8,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned ADDR_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [NUM_THR*TEMP_W-1:0] thr_flat,
    output logic [TEMP_W-1:0]         oos_level,
    output logic [CNT_W-1:0]          persist_len,
    output logic [2*NUM_THR:0]        irq_en,
    output logic [2*NUM_THR:0]        clr_mask
);
    localparam int unsigned MASK_W    = 2 * NUM_THR + 1;
    localparam int unsigned A_LEVEL   = NUM_THR;
    localparam int unsigned A_PERSIST = NUM_THR + 1;
    localparam int unsigned A_ENABLE  = NUM_THR + 2;
    localparam int unsigned A_CLEAR   = NUM_THR + 3;

    // One register per threshold, generated.
    for (genvar k = 0; k < NUM_THR; k++) begin : g_thr
        logic [TEMP_W-1:0] thr_q;
        // Purpose: load threshold k on a write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                thr_q <= '1;
            else if (wr_en && (wr_addr == ADDR_W'(k)))
                thr_q <= wr_data[TEMP_W-1:0];
        end
        assign thr_flat[k*TEMP_W +: TEMP_W] = thr_q;
    end

    // Purpose: load the trip level, persistence length and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oos_level   <= '1;
            persist_len <= CNT_W'(1);
            irq_en      <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_LEVEL))
                oos_level <= wr_data[TEMP_W-1:0];
            if (wr_addr == ADDR_W'(A_PERSIST))
                persist_len <= wr_data[CNT_W-1:0];
            if (wr_addr == ADDR_W'(A_ENABLE))
                irq_en <= wr_data[MASK_W-1:0];
        end
    end

    // Purpose: present the clear mask only during a clear write.
    always_comb begin
        clr_mask = '0;
        if (wr_en && (wr_addr == ADDR_W'(A_CLEAR)))
            clr_mask = wr_data[MASK_W-1:0];
    end
endmodule

// File: rtl/tm_cross_detect.sv
// Module: tm_cross_detect
// Compares the current sample and the previous one against one threshold.
// Keeps the upward and downward log bits and the live above-threshold bit.
// Assumes prev_ok is low until a first sample has been stored upstream.
// A log bit being set wins over a clear in the same cycle.
module tm_cross_detect
    import thermal_mon_pkg::*;
#(
    parameter int unsigned TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic              prev_ok,
    input  logic [TEMP_W-1:0] prev_temp,
    input  logic [TEMP_W-1:0] cur_temp,
    input  logic [TEMP_W-1:0] thr,
    input  logic              clr_up,
    input  logic              clr_dn,
    output logic              up_log,
    output logic              dn_log,
    output logic              above
);
    xing_e xing;
    logic  cur_hi;
    logic  prev_hi;

    // Purpose: classify the crossing between the two samples.
    always_comb begin
        cur_hi  = (cur_temp >= thr);
        prev_hi = (prev_temp >= thr);
        xing    = XING_NONE;
        if (sample_valid && prev_ok) begin
            if (cur_hi && !prev_hi)
                xing = XING_UP;
            else if (!cur_hi && prev_hi)
                xing = XING_DOWN;
        end
    end

    // Purpose: update the log bits and the live side bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_log <= 1'b0;
            dn_log <= 1'b0;
            above  <= 1'b0;
        end else begin
            up_log <= (xing == XING_UP)   | (up_log & ~clr_up);
            dn_log <= (xing == XING_DOWN) | (dn_log & ~clr_dn);
            if (sample_valid)
                above <= cur_hi;
        end
    end
endmodule

// File: rtl/tm_oos_detect.sv
// Module: tm_oos_detect
// Counts consecutive samples taken while throttling is active and the
// temperature is at or above the trip level. Once the count reaches the
// persistence length (0 acts as 1), it sets the live and sticky
// out-of-spec bits. The count saturates. The sticky bit is re-latched as
// long as the live bit holds, so a clear takes effect only once the live
// bit has dropped.
module tm_oos_detect #(
    parameter int unsigned TEMP_W = 8,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic              throttle_on,
    input  logic [TEMP_W-1:0] cur_temp,
    input  logic [TEMP_W-1:0] oos_level,
    input  logic [CNT_W-1:0]  persist_len,
    input  logic              clr,
    output logic              oos_live,
    output logic              oos_sticky
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] run_nx;
    logic [CNT_W-1:0] need;
    logic             qual;
    logic             live_nx;

    // Purpose: compute the next run length and the next live state.
    always_comb begin
        qual = throttle_on && (cur_temp >= oos_level);
        need = (persist_len == '0) ? CNT_W'(1) : persist_len;
        if (!qual)
            run_nx = '0;
        else if (run_cnt == CNT_MAX)
            run_nx = run_cnt;
        else
            run_nx = run_cnt + CNT_W'(1);
        live_nx = sample_valid ? (qual && (run_nx >= need)) : oos_live;
    end

    // Purpose: hold the run counter, the live bit and the sticky bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt    <= '0;
            oos_live   <= 1'b0;
            oos_sticky <= 1'b0;
        end else begin
            if (sample_valid)
                run_cnt <= run_nx;
            oos_live   <= live_nx;
            oos_sticky <= live_nx | (oos_sticky & ~clr);
        end
    end
endmodule

// File: rtl/thermal_oos_monitor.sv
// Module: thermal_oos_monitor (top)
// Thermal threshold and out-of-spec monitor. It stores the previous sample,
// runs one crossing detector per threshold and one out-of-spec detector,
// and builds the status word and the interrupt line.
// Status layout for N thresholds: bits 2k/2k+1 are the up/down logs of
// threshold k, bit 2N is the out-of-spec sticky bit, bit 2N+1 the
// out-of-spec live bit, and bits 2N+2+k the live above-threshold bits.
// Assumes the clock and reset are synchronous to the samples.
module thermal_oos_monitor
    import thermal_mon_pkg::*;
#(
    parameter int unsigned NUM_THR = 2,
    parameter int unsigned TEMP_W  = 8,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned DATA_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_valid,
    input  logic [TEMP_W-1:0]       temp_code,
    input  logic                    throttle_on,
    input  logic                    wr_en,
    input  logic [CFG_ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [3*NUM_THR+1:0]    status,
    output logic                    irq
);
    localparam int unsigned MASK_W = 2 * NUM_THR + 1;
    localparam int unsigned B_STK  = 2 * NUM_THR;
    localparam int unsigned B_LIVE = 2 * NUM_THR + 1;
    localparam int unsigned B_ABV  = 2 * NUM_THR + 2;

    logic [NUM_THR*TEMP_W-1:0] thr_flat;
    logic [TEMP_W-1:0]         oos_level;
    logic [CNT_W-1:0]          persist_len;
    logic [MASK_W-1:0]         irq_en;
    logic [MASK_W-1:0]         clr_mask;
    logic [TEMP_W-1:0]         prev_temp;
    logic                      prev_ok;
    logic [MASK_W-1:0]         sticky_vec;
    logic [NUM_THR-1:0]        above_vec;
    logic                      oos_live;

    tm_cfg_regs #(
        .NUM_THR (NUM_THR),
        .TEMP_W  (TEMP_W),
        .CNT_W   (CNT_W),
        .DATA_W  (DATA_W),
        .ADDR_W  (CFG_ADDR_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .thr_flat    (thr_flat),
        .oos_level   (oos_level),
        .persist_len (persist_len),
        .irq_en      (irq_en),
        .clr_mask    (clr_mask)
    );

    // Purpose: remember the last sample for crossing detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_temp <= '0;
            prev_ok   <= 1'b0;
        end else if (sample_valid) begin
            prev_temp <= temp_code;
            prev_ok   <= 1'b1;
        end
    end

    for (genvar k = 0; k < NUM_THR; k++) begin : g_xd
        tm_cross_detect #(
            .TEMP_W (TEMP_W)
        ) u_xd (
            .clk          (clk),
            .rst_n        (rst_n),
            .sample_valid (sample_valid),
            .prev_ok      (prev_ok),
            .prev_temp    (prev_temp),
            .cur_temp     (temp_code),
            .thr          (thr_flat[k*TEMP_W +: TEMP_W]),
            .clr_up       (clr_mask[2*k]),
            .clr_dn       (clr_mask[2*k+1]),
            .up_log       (sticky_vec[2*k]),
            .dn_log       (sticky_vec[2*k+1]),
            .above        (above_vec[k])
        );
    end

    tm_oos_detect #(
        .TEMP_W (TEMP_W),
        .CNT_W  (CNT_W)
    ) u_oos (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .throttle_on  (throttle_on),
        .cur_temp     (temp_code),
        .oos_level    (oos_level),
        .persist_len  (persist_len),
        .clr          (clr_mask[B_STK]),
        .oos_live     (oos_live),
        .oos_sticky   (sticky_vec[B_STK])
    );

    // Purpose: assemble the status word and the interrupt line.
    always_comb begin
        status                        = '0;
        status[B_STK:0]               = sticky_vec;
        status[B_LIVE]                = oos_live;
        status[B_ABV +: NUM_THR]      = above_vec;
        irq                           = |(sticky_vec & irq_en);
    end
endmodule

// File: rtl/tm_monitor_chk.sv
// Module: tm_monitor_chk
// Assertion checker for thermal_oos_monitor, attached by the bind below.
module tm_monitor_chk #(
    parameter int unsigned NUM_THR = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sample_valid,
    input logic                   throttle_on,
    input logic [2*NUM_THR:0]     clr_mask,
    input logic [2*NUM_THR:0]     irq_en,
    input logic [2*NUM_THR:0]     sticky_vec,
    input logic                   oos_live,
    input logic [3*NUM_THR+1:0]   status,
    input logic                   irq
);
    localparam int unsigned B_STK = 2 * NUM_THR;

    for (genvar b = 0; b <= B_STK; b++) begin : g_bit
        // R9
        sticky_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sticky_vec[b]) |-> $past(clr_mask[b]));
    end

    for (genvar b = 0; b < B_STK; b++) begin : g_log
        // R2
        log_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sticky_vec[b]) |-> $past(sample_valid));
    end

    // R8
    live_needs_throttle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oos_live) |-> $past(sample_valid && throttle_on));

    // R6
    live_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oos_live |-> sticky_vec[B_STK]);

    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);

    // R11
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_valid && (clr_mask == '0)) |=> $stable(status));
endmodule

bind thermal_oos_monitor tm_monitor_chk #(
    .NUM_THR (NUM_THR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .throttle_on  (throttle_on),
    .clr_mask     (clr_mask),
    .irq_en       (irq_en),
    .sticky_vec   (sticky_vec),
    .oos_live     (oos_live),
    .status       (status),
    .irq          (irq)
);

// File: tb/thermal_oos_monitor_tb.sv
// Directed testbench for thermal_oos_monitor (defaults: N=2, 8-bit data).
module thermal_oos_monitor_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sample_valid;
    logic [7:0] temp_code;
    logic       throttle_on;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [7:0] status;
    logic       irq;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    thermal_oos_monitor u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .temp_code    (temp_code),
        .throttle_on  (throttle_on),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .status       (status),
        .irq          (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic take_sample(input logic [7:0] t, input logic thr_on);
        @(negedge clk);
        sample_valid = 1'b1; temp_code = t; throttle_on = thr_on;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 status", status, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_first_and_up;
        cfg_write(3'd0, 8'd50);
        cfg_write(3'd1, 8'd80);
        take_sample(8'd60, 1'b0);
        check("R4 first sample no log, R5 above0", status, 8'h40);
        take_sample(8'd70, 1'b0);
        check("R4 same side", status, 8'h40);
        take_sample(8'd85, 1'b0);
        check("R2 up thr1, R5 above1", status, 8'hC4);
    endtask

    task automatic t_down_and_equal;
        take_sample(8'd45, 1'b0);
        check("R3 down both", status, 8'h0E);
        take_sample(8'd50, 1'b0);
        check("R2 up at equal", status, 8'h4F);
    endtask

    task automatic t_clear_and_hold;
        cfg_write(3'd5, 8'h0F);
        check("R9 clear logs", status, 8'h40);
        cfg_write(3'd0, 8'd10);
        repeat (3) @(negedge clk);
        check("R11 hold on config write", status, 8'h40);
        cfg_write(3'd0, 8'd50);
    endtask

    task automatic t_oos_persist;
        cfg_write(3'd2, 8'd90);
        cfg_write(3'd3, 8'd3);
        take_sample(8'd95, 1'b1);
        take_sample(8'd95, 1'b1);
        check("R6 not yet at 2 of 3", status, 8'hC4);
        take_sample(8'd95, 1'b1);
        check("R6 live and sticky at 3", status, 8'hF4);
        take_sample(8'd85, 1'b1);
        check("R7 live drops sticky stays", status, 8'hD4);
    endtask

    task automatic t_throttle_off;
        cfg_write(3'd5, 8'h10);
        check("R9 clear sticky", status, 8'hC4);
        for (int i = 0; i < 4; i++) take_sample(8'd100, 1'b0);
        check("R8 no oos without throttle", status, 8'hC4);
    endtask

    task automatic t_set_beats_clear;
        cfg_write(3'd3, 8'd0);
        @(negedge clk);
        sample_valid = 1'b1; temp_code = 8'd100; throttle_on = 1'b1;
        wr_en = 1'b1; wr_addr = 3'd5; wr_data = 8'h10;
        @(negedge clk);
        sample_valid = 1'b0; wr_en = 1'b0;
        check("R6 persist 0 acts as 1, R9 set wins", status, 8'hF4);
        cfg_write(3'd5, 8'h10);
        check("R9 sticky kept while live", status, 8'hF4);
        take_sample(8'd70, 1'b1);
        check("R7 cool sample", status, 8'h5C);
        cfg_write(3'd5, 8'h1F);
        check("R9 clear all", status, 8'h40);
    endtask

    task automatic t_irq;
        take_sample(8'd90, 1'b0);
        check("R2 up thr1 again", status, 8'hC4);
        cfg_write(3'd4, 8'h10);
        check("R10 masked", {7'd0, irq}, 8'h00);
        cfg_write(3'd4, 8'h04);
        check("R10 enabled", {7'd0, irq}, 8'h01);
        cfg_write(3'd5, 8'h04);
        check("R10 cleared source", {7'd0, irq}, 8'h00);
        check("R11 status after clear", status, 8'hC0);
    endtask

    initial begin
        rst_n = 1'b0; sample_valid = 1'b0; temp_code = '0; throttle_on = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_and_up();
        t_down_and_equal();
        t_clear_and_hold();
        t_oos_persist();
        t_throttle_off();
        t_set_beats_clear();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule